// File: doc/BRIEF.md
# Multi-Window Message Mailbox Link

This block carries variable-length messages from a producer to a consumer through a small group of 32-bit mailbox windows. These windows are modelled inside the block. The sender takes a message as a stream of 32-bit words with a byte length. It splits the message into rounds of up to `NWIN` words. For each round it places word `i` in window `NWIN-1-i`, and it writes the words from the highest-numbered word down to word 0. The top window therefore always receives the round's first word, and it receives it last. Only the top window is unmasked at the receiving side, so its write is the doorbell that raises the receiver interrupt.

The receiver reacts to that interrupt. It reads the windows in ascending order, putting window `j` at round position `NWIN-1-j`, and clears each window as it reads it. The top window is cleared last, which drops the interrupt and tells the sender the round has been consumed. The receiver then streams out exactly `NWIN` words with `out_last` on the final word of the round. Positions that the final round did not fill come out as zero. A trailing partial word keeps only its valid low bytes. A round whose first word is zero would never ring the doorbell, so the sender refuses it: it flags an error, delivers nothing of that round, and swallows the rest of the message.

Both streams follow valid/ready rules. A beat transfers on a clock edge where valid and ready are both high. The sender holds `in_ready` low while it is not collecting words. The producer must hold `in_len` constant for every beat of one message. The consumer may hold `out_ready` low for any time, and `out_data`/`out_last` stay frozen until it accepts the beat.

Top module: `msg_window_link`

## Requirements
- R1: For every round the receiver emits `NWIN` words in message order (word 0 of the round first), with `out_last` high on the `NWIN`-th word only.
- R2: `rx_irq` rises only on the clock edge after a write to the top window (index `NWIN-1`). It stays high until that window is cleared.
- R3: The sender starts writing a round only when the top window reads zero, so no window is written while it still holds unread data.
- R4: A message of more than `NWIN` words goes out in consecutive rounds of `NWIN` words. In the final round, the positions after the last message word are delivered as zero.
- R5: When the length in bytes leaves `k` = 1, 2 or 3 bytes in the last word, only bits `[8k-1:0]` of that word are kept and the upper bits read zero.
- R6: If the first word of a round is zero after masking, `tx_err` pulses for one cycle and that round and all later rounds are not delivered. The remaining words of the message are still accepted and dropped, and `tx_done` does not pulse for the message.
- R7: The receiver clears windows in ascending index order and clears the top window last. `rx_irq` is low once a round has been read out and nothing new was written.
- R8: `tx_busy` is high from the first accepted beat until the message finishes. `tx_done` pulses once when the final round of a message has been written. `tx_done` and `tx_err` are never high together.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: After reset all outputs are low: `in_ready`, `out_valid`, `rx_irq`, `tx_busy`, `tx_done`, `tx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a message word |
| in_ready | output | 1 | Sender takes the word at this edge |
| in_data | input | 32 | Message word |
| in_len | input | 8 | Message length in bytes, 1 to 255, held for the whole message |
| tx_busy | output | 1 | Sender is handling a message |
| tx_done | output | 1 | One-cycle pulse: message fully written |
| tx_err | output | 1 | One-cycle pulse: round with zero lead word refused |
| rx_irq | output | 1 | Receiver interrupt from the top window |
| out_valid | output | 1 | Receiver offers a round word |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_data | output | 32 | Round word in message order |
| out_last | output | 1 | Final word of the round |

## Verification
The bench builds the link with three windows. With three windows, a 26-byte message needs two full rounds plus a one-word round that carries a masked two-byte tail. It also makes a 13-byte message whose masked tail becomes the zero lead word of its second round, which tests R5 and R6 together. Three windows also let a zero lead word show up in a later round after good rounds have already gone through. A 255-byte message with the consumer stalling on an irregular pattern keeps the sender waiting on the top window while the receiver is still emitting, so later rounds overlap with the output stream.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 8;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_FILL,
    TX_CHECK,
    TX_WAIT,
    TX_WRITE,
    TX_DRAIN
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_READ,
    RX_EMIT
  } rx_state_t;

  function automatic logic [WORD_W-1:0] keep_low_bytes(input logic [WORD_W-1:0] w,
                                                       input logic [1:0] nbytes);
    logic [WORD_W-1:0] r;
    case (nbytes)
      2'd1:    r = w & 32'h0000_00FF;
      2'd2:    r = w & 32'h0000_FFFF;
      2'd3:    r = w & 32'h00FF_FFFF;
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mwl_winbank.sv
module mwl_winbank #(
  parameter int unsigned NWIN = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             set_en,
  input  logic [((NWIN>1)?$clog2(NWIN):1)-1:0] set_idx,
  input  logic [mwl_pkg::WORD_W-1:0]       set_data,
  input  logic                             clr_en,
  input  logic [((NWIN>1)?$clog2(NWIN):1)-1:0] clr_idx,
  input  logic [((NWIN>1)?$clog2(NWIN):1)-1:0] rd_idx,
  output logic [mwl_pkg::WORD_W-1:0]       rd_data,
  output logic                             irq,
  output logic                             top_empty
);
  import mwl_pkg::*;

  localparam int unsigned IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NWIN - 1);

  logic [WORD_W-1:0] win_q [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[g] <= '0;
      end else if (clr_en && clr_idx == IDXW'(g)) begin
        win_q[g] <= '0;
      end else if (set_en && set_idx == IDXW'(g)) begin
        win_q[g] <= win_q[g] | set_data;
      end
    end
  end

  assign rd_data   = win_q[rd_idx];
  assign irq       = |win_q[NWIN-1];
  assign top_empty = ~(|win_q[NWIN-1]);

  // A window must be drained before it is written again.
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (win_q[set_idx] == '0));

  // The doorbell only comes from the top window.
  p_irq_from_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_en && set_idx == TOP_IDX));

  // The interrupt only falls when the top window is cleared.
  p_irq_drop_by_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_en && clr_idx == TOP_IDX));

  p_no_set_clear_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en && set_idx == clr_idx));

endmodule

// File: rtl/mwl_tx.sv
module mwl_tx #(
  parameter int unsigned NWIN = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [mwl_pkg::WORD_W-1:0]       in_data,
  input  logic [mwl_pkg::LEN_W-1:0]        in_len,
  input  logic                             top_empty,
  output logic                             wr_en,
  output logic [((NWIN>1)?$clog2(NWIN):1)-1:0] wr_idx,
  output logic [mwl_pkg::WORD_W-1:0]       wr_data,
  output logic                             busy,
  output logic                             done,
  output logic                             err
);
  import mwl_pkg::*;

  localparam int unsigned IDXW  = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned LEFTW = LEN_W - 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NWIN - 1);

  tx_state_t          state_q;
  logic [LEFTW-1:0]   left_q;
  logic [1:0]         tail_q;
  logic [IDXW-1:0]    cnt_q;
  logic [IDXW-1:0]    widx_q;
  logic [WORD_W-1:0]  buf_q [NWIN];
  logic               done_q, err_q;

  logic               take;
  logic [WORD_W-1:0]  word_in;
  logic [LEFTW-1:0]   start_left;

  assign in_ready   = (state_q == TX_FILL) || (state_q == TX_DRAIN);
  assign take       = in_valid && in_ready;
  assign word_in    = (left_q == LEFTW'(1) && tail_q != 2'd0) ?
                      keep_low_bytes(in_data, tail_q) : in_data;
  assign start_left = LEFTW'(({1'b0, in_len} + 9'd3) >> 2);

  assign wr_en   = (state_q == TX_WRITE);
  assign wr_idx  = TOP_IDX - widx_q;
  assign wr_data = buf_q[widx_q];
  assign busy    = (state_q != TX_IDLE);
  assign done    = done_q;
  assign err     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      left_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (in_valid) begin
            left_q  <= start_left;
            tail_q  <= in_len[1:0];
            cnt_q   <= '0;
            state_q <= TX_FILL;
          end
        end
        TX_FILL: begin
          if (take) begin
            left_q <= left_q - LEFTW'(1);
            if (cnt_q == TOP_IDX || left_q == LEFTW'(1)) begin
              widx_q  <= cnt_q;
              state_q <= TX_CHECK;
            end else begin
              cnt_q <= cnt_q + IDXW'(1);
            end
          end
        end
        TX_CHECK: begin
          if (buf_q[0] == '0) begin
            err_q   <= 1'b1;
            state_q <= (left_q != '0) ? TX_DRAIN : TX_IDLE;
          end else begin
            state_q <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (top_empty) state_q <= TX_WRITE;
        end
        TX_WRITE: begin
          if (widx_q == '0) begin
            cnt_q <= '0;
            if (left_q == '0) begin
              done_q  <= 1'b1;
              state_q <= TX_IDLE;
            end else begin
              state_q <= TX_FILL;
            end
          end else begin
            widx_q <= widx_q - IDXW'(1);
          end
        end
        TX_DRAIN: begin
          if (take) begin
            left_q <= left_q - LEFTW'(1);
            if (left_q == LEFTW'(1)) state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) buf_q[i] <= '0;
    end else if (state_q == TX_FILL && take) begin
      buf_q[cnt_q] <= word_in;
    end
  end

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // The top window is written last, and only once the lower ones are in.
  p_top_written_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == TOP_IDX) |=> !wr_en);

endmodule

// File: rtl/mwl_rx.sv
module mwl_rx #(
  parameter int unsigned NWIN = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             irq,
  output logic [((NWIN>1)?$clog2(NWIN):1)-1:0] rd_idx,
  input  logic [mwl_pkg::WORD_W-1:0]       rd_data,
  output logic                             clr_en,
  output logic [((NWIN>1)?$clog2(NWIN):1)-1:0] clr_idx,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [mwl_pkg::WORD_W-1:0]       out_data,
  output logic                             out_last
);
  import mwl_pkg::*;

  localparam int unsigned IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NWIN - 1);

  rx_state_t         state_q;
  logic [IDXW-1:0]   j_q;
  logic [IDXW-1:0]   p_q;
  logic [WORD_W-1:0] buf_q [NWIN];

  assign rd_idx    = j_q;
  assign clr_idx   = j_q;
  assign clr_en    = (state_q == RX_READ);
  assign out_valid = (state_q == RX_EMIT);
  assign out_data  = buf_q[p_q];
  assign out_last  = out_valid && (p_q == TOP_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      j_q     <= '0;
      p_q     <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (irq) begin
            j_q     <= '0;
            state_q <= RX_READ;
          end
        end
        RX_READ: begin
          if (j_q == TOP_IDX) begin
            p_q     <= '0;
            state_q <= RX_EMIT;
          end else begin
            j_q <= j_q + IDXW'(1);
          end
        end
        RX_EMIT: begin
          if (out_ready) begin
            if (p_q == TOP_IDX) state_q <= RX_IDLE;
            else                p_q <= p_q + IDXW'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) buf_q[i] <= '0;
    end else if (state_q == RX_READ) begin
      buf_q[TOP_IDX - j_q] <= rd_data;
    end
  end

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // Windows are cleared one after another, lowest index first.
  p_clear_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx != '0) |-> ($past(clr_en) && $past(clr_idx) == clr_idx - IDXW'(1)));

  p_read_on_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_en) |-> $past(irq));

endmodule

// File: rtl/msg_window_link.sv
module msg_window_link #(
  parameter int unsigned NWIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [7:0]  in_len,
  output logic        tx_busy,
  output logic        tx_done,
  output logic        tx_err,
  output logic        rx_irq,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last
);
  import mwl_pkg::*;

  localparam int unsigned IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic              wr_en;
  logic [IDXW-1:0]   wr_idx;
  logic [WORD_W-1:0] wr_data;
  logic              clr_en;
  logic [IDXW-1:0]   clr_idx;
  logic [IDXW-1:0]   rd_idx;
  logic [WORD_W-1:0] rd_data;
  logic              irq;
  logic              top_empty;

  mwl_tx #(.NWIN(NWIN)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_len    (in_len),
    .top_empty (top_empty),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .busy      (tx_busy),
    .done      (tx_done),
    .err       (tx_err)
  );

  mwl_winbank #(.NWIN(NWIN)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (wr_en),
    .set_idx   (wr_idx),
    .set_data  (wr_data),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .irq       (irq),
    .top_empty (top_empty)
  );

  mwl_rx #(.NWIN(NWIN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  assign rx_irq = irq;

endmodule

// File: tb/test_msg_window_link.sv
module test_msg_window_link;

  localparam int NW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [7:0]  in_len = '0;
  logic        tx_busy, tx_done, tx_err, rx_irq;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;
  int ready_mode = 0;
  bit finished = 1'b0;

  logic [31:0] msg_w [0:63];
  logic [32:0] exp_q [$];

  always #10 clk = ~clk;

  msg_window_link #(.NWIN(NW)) i_msg_window_link (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_len(in_len),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_err(tx_err), .rx_irq(rx_irq),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output monitor: consumer pacing plus comparison against the model queue.
  always @(negedge clk) begin
    cyc++;
    if (tx_done) done_cnt++;
    if (tx_err)  err_cnt++;
    case (ready_mode)
      1:       out_ready = (cyc % 3) != 0;
      2:       out_ready = (cyc % 5) < 2;
      default: out_ready = 1'b1;
    endcase
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected word", {31'd0, out_last, out_data}, 64'd0);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        check(out_data == e[31:0], "R1/R4/R5 word", {32'd0, out_data}, {32'd0, e[31:0]});
        check(out_last == e[32],   "R1 last flag", {63'd0, out_last}, {63'd0, e[32]});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] model_word(input int idx, input int len);
    int nw = (len + 3) / 4;
    int k = len % 4;
    logic [31:0] w = msg_w[idx];
    if (idx == nw - 1 && k != 0) w = w & ((32'd1 << (8 * k)) - 32'd1);
    return w;
  endfunction

  // Reference: rounds of NW words, zero padded; zero lead word stops delivery.
  function automatic int model_msg(input int len);
    int nw = (len + 3) / 4;
    for (int s = 0; s < nw; s += NW) begin
      if (model_word(s, len) == 32'd0) return 1;
      for (int p = 0; p < NW; p++) begin
        logic [31:0] v = (s + p < nw) ? model_word(s + p, len) : 32'd0;
        exp_q.push_back({(p == NW - 1), v});
      end
    end
    return 0;
  endfunction

  task automatic send_msg(input int len, input string tag);
    int nw = (len + 3) / 4;
    int exp_err;
    int d0 = done_cnt;
    int e0 = err_cnt;
    bit rdy;
    exp_err = model_msg(len);
    for (int k = 0; k < nw; ) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = msg_w[k];
      in_len   = len[7:0];
      rdy      = in_ready;
      @(posedge clk);
      if (rdy) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (tx_busy) @(negedge clk);
    repeat (8 * NW + 20) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R4 all rounds delivered"}, 64'(exp_q.size()), 64'd0);
    check((err_cnt - e0) == exp_err, {tag, " R6 error pulses"}, 64'(err_cnt - e0), 64'(exp_err));
    check((done_cnt - d0) == (1 - exp_err), {tag, " R8 done pulses"}, 64'(done_cnt - d0), 64'(1 - exp_err));
    check(rx_irq == 1'b0, {tag, " R7 irq low after readout"}, {63'd0, rx_irq}, 64'd0);
    check(tx_busy == 1'b0, {tag, " R8 idle"}, {63'd0, tx_busy}, 64'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0,  "R10 in_ready", {63'd0, in_ready}, 64'd0);
    check(out_valid == 1'b0, "R10 out_valid", {63'd0, out_valid}, 64'd0);
    check(rx_irq == 1'b0,    "R10 rx_irq", {63'd0, rx_irq}, 64'd0);
    check(tx_busy == 1'b0,   "R10 tx_busy", {63'd0, tx_busy}, 64'd0);
    check({tx_done, tx_err} == 2'b00, "R10 pulses", {62'd0, tx_done, tx_err}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: single word, padded round
    msg_w[0] = 32'h1122_3344;
    send_msg(4, "one word");

    // R1: exactly one full round
    msg_w[0] = 32'hA000_0001; msg_w[1] = 32'hB000_0002; msg_w[2] = 32'hC000_0003;
    send_msg(12, "full round");

    // R4 + R5: 7 words, last word 2 bytes
    for (int i = 0; i < 7; i++) msg_w[i] = 32'h0101_0101 * (i + 1) + 32'hAABB_0000;
    send_msg(26, "three rounds tail2");

    // R5: two words, 1-byte tail
    msg_w[0] = 32'hDEAD_BEEF; msg_w[1] = 32'h1234_5678;
    send_msg(5, "tail1");

    // R5: 3-byte tail in a single word
    msg_w[0] = 32'hFF12_3456;
    send_msg(3, "tail3");

    // R6: zero lead in first round
    msg_w[0] = 32'h0; msg_w[1] = 32'h5;
    send_msg(8, "zero lead r0");

    // R6: zero lead in second round after a good round
    msg_w[0] = 32'h1; msg_w[1] = 32'h2; msg_w[2] = 32'h3; msg_w[3] = 32'h0; msg_w[4] = 32'h9;
    send_msg(20, "zero lead r1");

    // R5 + R6: masked tail becomes a zero lead word
    msg_w[0] = 32'h7; msg_w[1] = 32'h8; msg_w[2] = 32'h9; msg_w[3] = 32'hFFFF_FF00;
    send_msg(13, "masked lead");

    // R9 + R3: long message under consumer back-pressure
    ready_mode = 1;
    for (int i = 0; i < 64; i++) msg_w[i] = 32'h0101_0101 * i + 32'h1;
    send_msg(255, "long stall3");
    ready_mode = 2;
    for (int i = 0; i < 64; i++) msg_w[i] = 32'h9E37_79B9 ^ (i << 5) ^ 32'h1;
    send_msg(200, "long stall5");
    ready_mode = 0;

    // R6 recovery: good message after errors
    msg_w[0] = 32'h0000_0100;
    send_msg(2, "after error");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule